// File: doc/BRIEF.md
# Multiport Register File with Condition Flags

This block is the architectural register store of an execution core. It holds 64 words of a parameterised width and serves three data read ports and two data write ports in a single clock domain. Entry 0 is a constant zero: it always reads as all zeros, and a write aimed at it is discarded. The write ports have no enable. Each one writes on every cycle, and a producer with nothing to write drives address 0. Words are always written in full.

Next to the data array the block keeps a small per-register store of two condition flags, zero and sign. These flags are derived from each word as it is written, so they always agree with the data. The instruction decoder reads them through two flag read ports of its own. Every read port, data or flag, is synchronous and returns its result the cycle after the address is presented. Beyond the arrays and the read-result registers the block holds no state. Forwarding of in-flight results belongs to the surrounding bypass network.

Top module: `regfile_flags`

## Requirements
- R1: While reset is high at a clock edge, every data read output becomes 0 and every flag read output becomes zero=1, sign=0. After reset every register reads 0 with zero=1, sign=0.
- R2: A data read port shows, after clock edge k, the contents of the register whose address was on that port at edge k (one cycle of latency).
- R3: Address 0 always reads as all zeros. A write to address 0 on either write port changes nothing.
- R4: A write presented at edge k is stored at that edge. A read of the same register presented at edge k returns the earlier contents, and a read presented at edge k+1 or later returns the new word.
- R5: The two write ports may write two different nonzero registers in the same cycle, and both words are stored.
- R6: When both write ports target the same nonzero register in one cycle, write port 1 wins for both the data and the flags.
- R7: The zero flag of a register is 1 exactly when the last word written to it had every bit 0.
- R8: The sign flag of a register equals bit WIDTH-1 of the last word written to it.
- R9: Each flag read port returns the flags of its addressed register one cycle after the address is presented. Address 0 always reports zero=1, sign=0.
- R10: When a flag port and a data port address the same register in the same cycle, the flags returned match the word returned: zero is 1 exactly when the word is 0, and sign equals its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr0_addr | input | 6 | Write port 0 register number (0 = no write) |
| wr0_data | input | WIDTH | Write port 0 word |
| wr1_addr | input | 6 | Write port 1 register number (0 = no write), wins on a clash |
| wr1_data | input | WIDTH | Write port 1 word |
| rd0_addr | input | 6 | Data read port 0 address |
| rd1_addr | input | 6 | Data read port 1 address |
| rd2_addr | input | 6 | Data read port 2 address |
| rd0_data | output | WIDTH | Data read port 0 result, one cycle after its address |
| rd1_data | output | WIDTH | Data read port 1 result |
| rd2_data | output | WIDTH | Data read port 2 result |
| flg0_addr | input | 6 | Decoder flag port 0 address |
| flg1_addr | input | 6 | Decoder flag port 1 address |
| flg0_zero | output | 1 | Flag port 0 zero flag |
| flg0_sign | output | 1 | Flag port 0 sign flag |
| flg1_zero | output | 1 | Flag port 1 zero flag |
| flg1_sign | output | 1 | Flag port 1 sign flag |

## Verification
A write and a read of the same register can fall in the same cycle, and so can two writes aimed at one register. The bench sets up the first by presenting a write and a read of one address together. It expects the old word back on that edge and the new word only from a read issued one cycle later. It sets up the second by giving both write ports one address with words that differ in value, zero-ness and top bit. A later read of data and flags then shows which port won, and the flags must agree with the data that was kept.

// File: rtl/regfile_flags_pkg.sv
package regfile_flags_pkg;

    localparam int unsigned RF_RD_PORTS   = 3;
    localparam int unsigned RF_FLAG_PORTS = 2;

    // which write port, if any, lands in a given slot this cycle
    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_P0   = 2'd1,
        WSRC_P1   = 2'd2
    } wsrc_e;

    typedef struct packed {
        logic zero;
        logic sign;
    } cflag_t;

    localparam cflag_t CFLAG_CLEAR = '{zero: 1'b1, sign: 1'b0};

    // port 1 has priority over port 0 on a clash
    function automatic wsrc_e pick_src(input logic hit0, input logic hit1);
        if (hit1) begin
            return WSRC_P1;
        end
        if (hit0) begin
            return WSRC_P0;
        end
        return WSRC_NONE;
    endfunction

    function automatic cflag_t make_flag(input logic all_zero, input logic top_bit);
        cflag_t f;
        f.zero = all_zero;
        f.sign = top_bit;
        return f;
    endfunction

endpackage

// File: rtl/rf_write_merge.sv
module rf_write_merge
    import regfile_flags_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] wr0_addr,
    input  logic [WIDTH-1:0]  wr0_data,
    input  logic [ADDR_W-1:0] wr1_addr,
    input  logic [WIDTH-1:0]  wr1_data,
    output wsrc_e             slot_src [DEPTH],
    output cflag_t            flag0,
    output cflag_t            flag1
);

    // flags follow the word being written
    assign flag0 = make_flag(wr0_data == '0, wr0_data[WIDTH-1]);
    assign flag1 = make_flag(wr1_data == '0, wr1_data[WIDTH-1]);

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        if (e == 0) begin : g_null
            // address 0 is the null write
            assign slot_src[e] = WSRC_NONE;
        end else begin : g_live
            logic hit0;
            logic hit1;
            assign hit0 = (wr0_addr == ADDR_W'(e));
            assign hit1 = (wr1_addr == ADDR_W'(e));
            assign slot_src[e] = pick_src(hit0, hit1);
        end
    end

endmodule

// File: rtl/rf_data_array.sv
module rf_data_array
    import regfile_flags_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NRD    = RF_RD_PORTS,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wsrc_e             slot_src [DEPTH],
    input  logic [WIDTH-1:0]  wr0_data,
    input  logic [WIDTH-1:0]  wr1_data,
    input  logic [ADDR_W-1:0] rd_addr  [NRD],
    output logic [WIDTH-1:0]  rd_data  [NRD]
);

    logic [WIDTH-1:0] cells [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        if (e == 0) begin : g_zero
            assign cells[e] = '0;
        end else begin : g_word
            logic [WIDTH-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= '0;
                end else begin
                    case (slot_src[e])
                        WSRC_P0: word_q <= wr0_data;
                        WSRC_P1: word_q <= wr1_data;
                        default: word_q <= word_q;
                    endcase
                end
            end
            assign cells[e] = word_q;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [WIDTH-1:0] out_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '0;
            end else begin
                out_q <= cells[rd_addr[p]];
            end
        end
        assign rd_data[p] = out_q;

        AST_REG0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[p] == '0) |=> (rd_data[p] == '0)); // R3

        AST_RESET_CLEARS_READ: assert property (@(posedge clk)
            rst |=> (rd_data[p] == '0)); // R1
    end

endmodule

// File: rtl/rf_flag_store.sv
module rf_flag_store
    import regfile_flags_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NFR    = RF_FLAG_PORTS,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wsrc_e             slot_src [DEPTH],
    input  cflag_t            flag0,
    input  cflag_t            flag1,
    input  logic [ADDR_W-1:0] fr_addr  [NFR],
    output cflag_t            fr_flag  [NFR]
);

    cflag_t slots [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        if (e == 0) begin : g_fixed
            assign slots[e] = CFLAG_CLEAR;
        end else begin : g_live
            cflag_t f_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_q <= CFLAG_CLEAR;
                end else begin
                    case (slot_src[e])
                        WSRC_P0: f_q <= flag0;
                        WSRC_P1: f_q <= flag1;
                        default: f_q <= f_q;
                    endcase
                end
            end
            assign slots[e] = f_q;
        end
    end

    for (genvar p = 0; p < NFR; p++) begin : g_rd
        cflag_t out_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= CFLAG_CLEAR;
            end else begin
                out_q <= slots[fr_addr[p]];
            end
        end
        assign fr_flag[p] = out_q;

        AST_REG0_FLAGS_FIXED: assert property (@(posedge clk) disable iff (rst)
            (fr_addr[p] == '0) |=> (fr_flag[p] == CFLAG_CLEAR)); // R9

        AST_RESET_CLEARS_FLAGS: assert property (@(posedge clk)
            rst |=> (fr_flag[p] == CFLAG_CLEAR)); // R1
    end

endmodule

// File: rtl/regfile_flags.sv
module regfile_flags
    import regfile_flags_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr0_addr,
    input  logic [WIDTH-1:0]  wr0_data,
    input  logic [ADDR_W-1:0] wr1_addr,
    input  logic [WIDTH-1:0]  wr1_data,
    input  logic [ADDR_W-1:0] rd0_addr,
    input  logic [ADDR_W-1:0] rd1_addr,
    input  logic [ADDR_W-1:0] rd2_addr,
    output logic [WIDTH-1:0]  rd0_data,
    output logic [WIDTH-1:0]  rd1_data,
    output logic [WIDTH-1:0]  rd2_data,
    input  logic [ADDR_W-1:0] flg0_addr,
    input  logic [ADDR_W-1:0] flg1_addr,
    output logic              flg0_zero,
    output logic              flg0_sign,
    output logic              flg1_zero,
    output logic              flg1_sign
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    wsrc_e             slot_src [DEPTH];
    cflag_t            flag0;
    cflag_t            flag1;
    logic [ADDR_W-1:0] rd_addr  [RF_RD_PORTS];
    logic [WIDTH-1:0]  rd_data  [RF_RD_PORTS];
    logic [ADDR_W-1:0] fr_addr  [RF_FLAG_PORTS];
    cflag_t            fr_flag  [RF_FLAG_PORTS];

    assign rd_addr[0] = rd0_addr;
    assign rd_addr[1] = rd1_addr;
    assign rd_addr[2] = rd2_addr;
    assign rd0_data   = rd_data[0];
    assign rd1_data   = rd_data[1];
    assign rd2_data   = rd_data[2];

    assign fr_addr[0] = flg0_addr;
    assign fr_addr[1] = flg1_addr;
    assign flg0_zero  = fr_flag[0].zero;
    assign flg0_sign  = fr_flag[0].sign;
    assign flg1_zero  = fr_flag[1].zero;
    assign flg1_sign  = fr_flag[1].sign;

    rf_write_merge #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) merge_i (
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data),
        .slot_src (slot_src),
        .flag0    (flag0),
        .flag1    (flag1)
    );

    rf_data_array #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .NRD(RF_RD_PORTS)) data_i (
        .clk      (clk),
        .rst      (rst),
        .slot_src (slot_src),
        .wr0_data (wr0_data),
        .wr1_data (wr1_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    rf_flag_store #(.ADDR_W(ADDR_W), .NFR(RF_FLAG_PORTS)) flags_i (
        .clk      (clk),
        .rst      (rst),
        .slot_src (slot_src),
        .flag0    (flag0),
        .flag1    (flag1),
        .fr_addr  (fr_addr),
        .fr_flag  (fr_flag)
    );

    // data array and flag store must agree on the same register
    AST_FLAG0_COHERENT: assert property (@(posedge clk) disable iff (rst)
        (flg0_addr == rd0_addr) |=>
        ((flg0_zero == (rd0_data == '0)) && (flg0_sign == rd0_data[WIDTH-1]))); // R10

    AST_FLAG1_COHERENT: assert property (@(posedge clk) disable iff (rst)
        (flg1_addr == rd1_addr) |=>
        ((flg1_zero == (rd1_data == '0)) && (flg1_sign == rd1_data[WIDTH-1]))); // R10

endmodule

// File: tb/regfile_flags_tb_top.sv
module regfile_flags_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned W  = 32;
    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] wr0_addr = '0, wr1_addr = '0;
    logic [W-1:0]  wr0_data = '0, wr1_data = '0;
    logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, rd2_addr = '0;
    logic [W-1:0]  rd0_data, rd1_data, rd2_data;
    logic [AW-1:0] flg0_addr = '0, flg1_addr = '0;
    logic          flg0_zero, flg0_sign, flg1_zero, flg1_sign;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    regfile_flags #(.WIDTH(W), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .rd0_addr(rd0_addr), .rd1_addr(rd1_addr), .rd2_addr(rd2_addr),
        .rd0_data(rd0_data), .rd1_data(rd1_data), .rd2_data(rd2_data),
        .flg0_addr(flg0_addr), .flg1_addr(flg1_addr),
        .flg0_zero(flg0_zero), .flg0_sign(flg0_sign),
        .flg1_zero(flg1_zero), .flg1_sign(flg1_sign)
    );

    typedef struct packed {
        logic [AW-1:0] wa0;
        logic [W-1:0]  wd0;
        logic [AW-1:0] wa1;
        logic [W-1:0]  wd1;
        logic [AW-1:0] ra0;
        logic [AW-1:0] ra1;
        logic [AW-1:0] ra2;
        logic [AW-1:0] fa0;
        logic [AW-1:0] fa1;
        logic [W-1:0]  e0;
        logic [W-1:0]  e1;
        logic [W-1:0]  e2;
        logic          ez0;
        logic          es0;
        logic          ez1;
        logic          es1;
    } vec_t;

    // each row: writes and reads in one cycle, expected reads seen after that edge
    localparam int unsigned NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{6'd5,  32'h0000_1234, 6'd9,  32'h8000_0001, 6'd5,  6'd9,  6'd0,  6'd5,  6'd9,
          32'h0,          32'h0,          32'h0,          1'b1, 1'b0, 1'b1, 1'b0},
        // null writes on both ports (R3)
        '{6'd0,  32'hFFFF_FFFF, 6'd0,  32'h0000_DEAD, 6'd5,  6'd9,  6'd0,  6'd9,  6'd0,
          32'h0000_1234, 32'h8000_0001, 32'h0,          1'b0, 1'b1, 1'b1, 1'b0},
        // clash on 7, port 1 must win (R6)
        '{6'd7,  32'h0000_0000, 6'd7,  32'hC000_0000, 6'd7,  6'd0,  6'd5,  6'd7,  6'd9,
          32'h0,          32'h0,          32'h0000_1234, 1'b1, 1'b0, 1'b0, 1'b1},
        '{6'd0,  32'h0,         6'd0,  32'h0,         6'd7,  6'd9,  6'd7,  6'd7,  6'd0,
          32'hC000_0000, 32'h8000_0001, 32'hC000_0000, 1'b0, 1'b1, 1'b1, 1'b0},
        // same-cycle read of 5 sees old word (R4)
        '{6'd5,  32'h0,         6'd12, 32'h7FFF_FFFF, 6'd5,  6'd12, 6'd3,  6'd5,  6'd12,
          32'h0000_1234, 32'h0,          32'h0,          1'b0, 1'b0, 1'b1, 1'b0},
        '{6'd0,  32'h0,         6'd0,  32'h0,         6'd5,  6'd12, 6'd0,  6'd12, 6'd5,
          32'h0,          32'h7FFF_FFFF, 32'h0,          1'b0, 1'b0, 1'b1, 1'b0},
        '{6'd63, 32'hFFFF_FFFF, 6'd0,  32'h0,         6'd63, 6'd5,  6'd12, 6'd5,  6'd63,
          32'h0,          32'h0,          32'h7FFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
        '{6'd0,  32'h0,         6'd0,  32'h0,         6'd63, 6'd0,  6'd9,  6'd63, 6'd12,
          32'hFFFF_FFFF, 32'h0,          32'h8000_0001, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_writes();
        wr0_addr = '0; wr0_data = '0;
        wr1_addr = '0; wr1_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 rd0", rd0_data, '0);
        chk("R1 flg0", {30'd0, flg0_zero, flg0_sign}, 32'd2);
        rst = 1'b0;

        // R2 R7 R8: vector walk, reads use contents before the row's writes
        for (int i = 0; i < int'(NVEC); i++) begin
            wr0_addr = VECS[i].wa0; wr0_data = VECS[i].wd0;
            wr1_addr = VECS[i].wa1; wr1_data = VECS[i].wd1;
            rd0_addr = VECS[i].ra0; rd1_addr = VECS[i].ra1; rd2_addr = VECS[i].ra2;
            flg0_addr = VECS[i].fa0; flg1_addr = VECS[i].fa1;
            cyc();
            chk("R2 rd0", rd0_data, VECS[i].e0);
            chk("R2 rd1", rd1_data, VECS[i].e1);
            chk("R2 rd2", rd2_data, VECS[i].e2);
            chk("R7 flg0 zero", 32'(flg0_zero), 32'(VECS[i].ez0));
            chk("R8 flg0 sign", 32'(flg0_sign), 32'(VECS[i].es0));
            chk("R9 flg1", {30'd0, flg1_zero, flg1_sign}, {30'd0, VECS[i].ez1, VECS[i].es1});
        end

        // R1: second reset wipes what was written
        idle_writes();
        rst = 1'b1;
        rd0_addr = 6'd63; rd1_addr = 6'd5; rd2_addr = 6'd12;
        flg0_addr = 6'd63; flg1_addr = 6'd9;
        cyc();
        rst = 1'b0;
        cyc();
        chk("R1 reg63", rd0_data, '0);
        chk("R1 reg5", rd1_data, '0);
        chk("R1 reg12", rd2_data, '0);
        chk("R1 flags63", {30'd0, flg0_zero, flg0_sign}, 32'd2);
        chk("R1 flags9", {30'd0, flg1_zero, flg1_sign}, 32'd2);

        // R3 R9: all-ones written to address 0 on both ports
        wr0_addr = 6'd0; wr0_data = 32'hFFFF_FFFF;
        wr1_addr = 6'd0; wr1_data = 32'hFFFF_FFFF;
        cyc();
        idle_writes();
        rd0_addr = 6'd0; flg0_addr = 6'd0;
        cyc();
        chk("R3 reg0", rd0_data, '0);
        chk("R9 reg0 flags", {30'd0, flg0_zero, flg0_sign}, 32'd2);

        // R4 R5: two distinct writes, same-cycle read of 20 sees old value
        wr0_addr = 6'd20; wr0_data = 32'h0000_0011;
        wr1_addr = 6'd21; wr1_data = 32'h0000_0022;
        rd0_addr = 6'd20;
        cyc();
        chk("R4 same-cycle old", rd0_data, '0);
        idle_writes();
        rd0_addr = 6'd20; rd1_addr = 6'd21;
        cyc();
        chk("R4 next-cycle new", rd0_data, 32'h0000_0011);
        chk("R5 port1 word", rd1_data, 32'h0000_0022);

        // R6: clash on 22, port 1 word 1 must survive with its flags
        wr0_addr = 6'd22; wr0_data = 32'h8000_0000;
        wr1_addr = 6'd22; wr1_data = 32'h0000_0001;
        cyc();
        idle_writes();
        rd0_addr = 6'd22; flg0_addr = 6'd22;
        cyc();
        chk("R6 data", rd0_data, 32'h0000_0001);
        chk("R6 flags", {30'd0, flg0_zero, flg0_sign}, 32'd0);

        // R7 R8: zero word to 23, negative word to 24
        wr0_addr = 6'd23; wr0_data = 32'h0;
        wr1_addr = 6'd24; wr1_data = 32'h8000_0000;
        cyc();
        idle_writes();
        flg0_addr = 6'd23; flg1_addr = 6'd24;
        rd0_addr = 6'd24;
        cyc();
        chk("R7 zero word", {30'd0, flg0_zero, flg0_sign}, 32'd2);
        chk("R8 negative word", {30'd0, flg1_zero, flg1_sign}, 32'd1);

        // R10: data and flags of 24 read together agree
        flg0_addr = 6'd24;
        cyc();
        chk("R10 zero vs data", 32'(flg0_zero), 32'(rd0_data == '0));
        chk("R10 sign vs data", 32'(flg0_sign), 32'(rd0_data[W-1]));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule